// File: doc/BRIEF.md
# Operand effective address generator

This block forms the address of a memory operand for a 32-bit CPU with a rich set of addressing modes. The decoder supplies it with a mode code, a variant selector for the auto-modify forms, the operand size, the base register contents, an index register value with its width, an instruction field (displacement, absolute address, immediate or vector number) with a width code, and the current program counter. One cycle later the block presents the effective address, the immediate operand when the mode carries one, and the updated base register value with a write strobe for the auto-modify forms.

For the two memory-indirect forms the block produces only the address of the pointer and raises a request output. The pointer read and the use of the pointer are left to the memory side. Requests may be issued back to back, one per clock, and each produces exactly one result cycle.

Encodings used throughout: `op_size` and `index_size` use 0 = byte, 1 = word (2 bytes) and 2 or 3 = long (4 bytes). `field_w` uses 0 = 2 bits, 1 = 3 bits, 2 = 4 bits, 3 = 8 bits, 4 = 16 bits, 5 = 24 bits, and 6 or 7 = 32 bits. `mode` uses 0 register direct, 1 register indirect, 2 indirect with displacement, 3 indexed displacement, 4 auto-modify, 5 absolute, 6 immediate, 7 PC-relative, 8 PC-relative with index, 9 memory indirect and 10 vector indirect. Codes 11 to 15 behave like code 0.

Top module: `ea_gen`

## Requirements
- R1: Every clock with `req_valid` high produces `out_valid` high on the next clock, and `out_valid` is low in the cycle after a clock where `req_valid` was low.
- R2: Mode 1 gives `ea` = `base_val`. Modes 0 and 11 to 15 give `ea` = 0 with `imm_valid`, `wb_en` and `ind_req` all low.
- R3: In mode 2, a 2-bit field (`field_w` = 0) is zero-extended and shifted left by the operand size code before it is added to `base_val`. A 16-bit or 32-bit field is sign-extended and added unscaled.
- R4: In mode 3, `ea` = `base_val` + sign-extended 16- or 32-bit field + (index shifted left by the operand size code). The index is `index_val` zero-extended from its low 8, 16 or 32 bits as `index_size` selects.
- R5: In mode 4, `mod_sel` selects 0 post-increment, 1 pre-decrement, 2 pre-increment or 3 post-decrement. The step is 1, 2 or 4 bytes per the operand size. `wb_val` is `base_val` plus or minus the step. `ea` is `wb_val` for the pre forms and `base_val` for the post forms.
- R6: `wb_en` is high only in the result cycle of a mode 4 request, and for exactly that one cycle per request.
- R7: In mode 5, an 8-bit address is filled with ones above bit 7. A 16-bit address is sign-extended. A 24-bit address is zero-extended. A 32-bit address is used unchanged.
- R8: In mode 6, `imm` is the field zero-extended from 3, 4, 8, 16 or 32 bits, `imm_valid` is high, and `ea` is 0.
- R9: In mode 7, `ea` = `pc` + the 8-bit or 16-bit field, sign-extended.
- R10: In mode 8, `ea` = `pc` + the index zero-extended per `index_size` and shifted left by the operand size code.
- R11: Mode 9 gives `ea` = `field[7:0]` × 4. Mode 10 gives `ea` = `VEC_BASE` + `field[6:0]` × 4, with `VEC_BASE` = 0x200 by default. Both raise `ind_req` for the result cycle, and no other mode raises it.
- R12: A synchronous active-high `rst` clears `out_valid`, `ea`, `imm`, `imm_valid`, `wb_en`, `wb_val` and `ind_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Operand request this cycle |
| mode | input | 4 | Addressing mode code |
| mod_sel | input | 2 | Auto-modify variant |
| op_size | input | 2 | Operand size code |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| index_size | input | 2 | Width of the index register |
| field | input | 32 | Instruction field: displacement, address, immediate or vector |
| field_w | input | 3 | Width code of `field` |
| pc | input | 32 | Program counter |
| out_valid | output | 1 | Result cycle |
| ea | output | 32 | Effective address, or pointer address for the indirect modes |
| imm | output | 32 | Immediate operand |
| imm_valid | output | 1 | `imm` holds an operand |
| wb_en | output | 1 | Base register write strobe |
| wb_val | output | 32 | New base register value |
| ind_req | output | 1 | Pointer read request |

## Verification
Each mode is driven with field values whose top bit is set and with values whose top bit is clear. This separates sign extension from zero extension and from ones-filling, and it exposes any mix-up between the 16-bit and 24-bit absolute rules. Index registers hold non-zero upper bits, so a wrong width selection or a missing scale by the operand size shows up as a different sum. All four auto-modify variants run at different operand sizes, which tells apart the pre and post forms, the direction of the step and its size. Back-to-back requests mixed with idle cycles show whether the write strobe lasts more than one cycle.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_REG  = 4'd0,
    M_IND  = 4'd1,
    M_DISP = 4'd2,
    M_IDX  = 4'd3,
    M_AUTO = 4'd4,
    M_ABS  = 4'd5,
    M_IMM  = 4'd6,
    M_PCR  = 4'd7,
    M_PCX  = 4'd8,
    M_MIND = 4'd9,
    M_VIND = 4'd10
  } ea_mode_e;

  localparam logic [2:0] FW2  = 3'd0;
  localparam logic [2:0] FW3  = 3'd1;
  localparam logic [2:0] FW4  = 3'd2;
  localparam logic [2:0] FW8  = 3'd3;
  localparam logic [2:0] FW16 = 3'd4;
  localparam logic [2:0] FW24 = 3'd5;

  localparam logic [1:0] AM_POST_INC = 2'd0;
  localparam logic [1:0] AM_PRE_DEC  = 2'd1;
  localparam logic [1:0] AM_PRE_INC  = 2'd2;
  localparam logic [1:0] AM_POST_DEC = 2'd3;
endpackage

// File: rtl/ea_field_ext.sv
module ea_field_ext
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] field,
  input  logic [2:0]    fw,
  output logic [AW-1:0] sext,
  output logic [AW-1:0] zext
);
  always_comb begin
    case (fw)
      FW2: begin
        zext = {{(AW-2){1'b0}}, field[1:0]};
        sext = {{(AW-2){field[1]}}, field[1:0]};
      end
      FW3: begin
        zext = {{(AW-3){1'b0}}, field[2:0]};
        sext = {{(AW-3){field[2]}}, field[2:0]};
      end
      FW4: begin
        zext = {{(AW-4){1'b0}}, field[3:0]};
        sext = {{(AW-4){field[3]}}, field[3:0]};
      end
      FW8: begin
        zext = {{(AW-8){1'b0}}, field[7:0]};
        sext = {{(AW-8){field[7]}}, field[7:0]};
      end
      FW16: begin
        zext = {{(AW-16){1'b0}}, field[15:0]};
        sext = {{(AW-16){field[15]}}, field[15:0]};
      end
      FW24: begin
        zext = {{(AW-24){1'b0}}, field[23:0]};
        sext = {{(AW-24){field[23]}}, field[23:0]};
      end
      default: begin
        zext = field;
        sext = field;
      end
    endcase
  end
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    index_size,
  input  logic [1:0]    op_size,
  output logic [AW-1:0] scaled
);
  logic [AW-1:0] ext;
  logic [1:0]    sh;

  always_comb begin
    case (index_size)
      2'd0:    ext = {{(AW-8){1'b0}}, index_val[7:0]};
      2'd1:    ext = {{(AW-16){1'b0}}, index_val[15:0]};
      default: ext = index_val;
    endcase
    sh     = (op_size == 2'd3) ? 2'd2 : op_size;
    scaled = ext << sh;
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int              AW       = 32,
  parameter logic [AW-1:0]   VEC_BASE = 'h200,
  parameter int              PTR_SH   = 2
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    mod_sel,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] field,
  input  logic [2:0]    field_w,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] f_sext,
  input  logic [AW-1:0] f_zext,
  input  logic [AW-1:0] idx_scaled,
  output logic [AW-1:0] nx_ea,
  output logic [AW-1:0] nx_imm,
  output logic          nx_imm_v,
  output logic          nx_wb_en,
  output logic [AW-1:0] nx_wb_val,
  output logic          nx_ind
);
  localparam int SZW = 2;

  logic [SZW-1:0] sh;
  logic [AW-1:0]  step;
  logic [AW-1:0]  inc_val;
  logic [AW-1:0]  dec_val;

  always_comb begin
    sh      = (op_size == 2'd3) ? 2'd2 : op_size;
    step    = {{(AW-1){1'b0}}, 1'b1} << sh;
    inc_val = base_val + step;
    dec_val = base_val - step;

    nx_ea     = '0;
    nx_imm    = '0;
    nx_imm_v  = 1'b0;
    nx_wb_en  = 1'b0;
    nx_wb_val = '0;
    nx_ind    = 1'b0;

    case (mode)
      M_IND:  nx_ea = base_val;
      M_DISP: nx_ea = base_val + ((field_w == FW2) ? (f_zext << sh) : f_sext);
      M_IDX:  nx_ea = base_val + f_sext + idx_scaled;
      M_AUTO: begin
        nx_wb_en = 1'b1;
        case (mod_sel)
          AM_POST_INC: begin nx_wb_val = inc_val; nx_ea = base_val; end
          AM_PRE_DEC:  begin nx_wb_val = dec_val; nx_ea = dec_val;  end
          AM_PRE_INC:  begin nx_wb_val = inc_val; nx_ea = inc_val;  end
          default:     begin nx_wb_val = dec_val; nx_ea = base_val; end
        endcase
      end
      M_ABS: begin
        case (field_w)
          FW8:     nx_ea = {{(AW-8){1'b1}}, field[7:0]};
          FW16:    nx_ea = f_sext;
          FW24:    nx_ea = f_zext;
          default: nx_ea = field;
        endcase
      end
      M_IMM: begin
        nx_imm   = f_zext;
        nx_imm_v = 1'b1;
      end
      M_PCR: nx_ea = pc + f_sext;
      M_PCX: nx_ea = pc + idx_scaled;
      M_MIND: begin
        nx_ea  = {{(AW-8){1'b0}}, field[7:0]} << PTR_SH;
        nx_ind = 1'b1;
      end
      M_VIND: begin
        nx_ea  = VEC_BASE + ({{(AW-7){1'b0}}, field[6:0]} << PTR_SH);
        nx_ind = 1'b1;
      end
      default: nx_ea = '0;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = 'h200,
  parameter int            PTR_SH   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [3:0]    mode,
  input  logic [1:0]    mod_sel,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    index_size,
  input  logic [AW-1:0] field,
  input  logic [2:0]    field_w,
  input  logic [AW-1:0] pc,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] imm,
  output logic          imm_valid,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          ind_req
);
  logic [AW-1:0] f_sext, f_zext, idx_scaled;
  logic [AW-1:0] nx_ea, nx_imm, nx_wb_val;
  logic          nx_imm_v, nx_wb_en, nx_ind;

  ea_field_ext #(.AW(AW)) ext_i (
    .field(field), .fw(field_w), .sext(f_sext), .zext(f_zext)
  );

  ea_index_scale #(.AW(AW)) idx_i (
    .index_val(index_val), .index_size(index_size), .op_size(op_size),
    .scaled(idx_scaled)
  );

  ea_calc #(.AW(AW), .VEC_BASE(VEC_BASE), .PTR_SH(PTR_SH)) calc_i (
    .mode(mode), .mod_sel(mod_sel), .op_size(op_size), .base_val(base_val),
    .field(field), .field_w(field_w), .pc(pc), .f_sext(f_sext),
    .f_zext(f_zext), .idx_scaled(idx_scaled), .nx_ea(nx_ea),
    .nx_imm(nx_imm), .nx_imm_v(nx_imm_v), .nx_wb_en(nx_wb_en),
    .nx_wb_val(nx_wb_val), .nx_ind(nx_ind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
      imm       <= '0;
      imm_valid <= 1'b0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
      ind_req   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      imm_valid <= req_valid & nx_imm_v;
      wb_en     <= req_valid & nx_wb_en;
      ind_req   <= req_valid & nx_ind;
      if (req_valid) begin
        ea     <= nx_ea;
        imm    <= nx_imm;
        wb_val <= nx_wb_val;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [3:0]  mode,
  input logic [1:0]  mod_sel,
  input logic [1:0]  op_size,
  input logic        out_valid,
  input logic [31:0] ea,
  input logic        imm_valid,
  input logic        wb_en,
  input logic [31:0] wb_val,
  input logic        ind_req
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  a_r6_wb_in_result: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> out_valid);
  a_r6_wb_auto: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 4'd4) |=> wb_en);
  a_r6_wb_not_other: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode != 4'd4) |=> !wb_en);
  a_r5_post_inc_long: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 4'd4 && mod_sel == 2'd0 && op_size == 2'd2)
      |=> (wb_val == ea + 32'd4));
  a_r5_pre_ea: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 4'd4 && (mod_sel == 2'd1 || mod_sel == 2'd2))
      |=> (ea == wb_val));
  a_r11_ind_req: assert property (@(posedge clk) disable iff (rst)
    ind_req |-> (out_valid && !wb_en && !imm_valid));
  a_r8_imm_no_addr: assert property (@(posedge clk) disable iff (rst)
    imm_valid |-> (ea == 32'd0));
endmodule

bind ea_gen ea_gen_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
  .mod_sel(mod_sel), .op_size(op_size), .out_valid(out_valid), .ea(ea),
  .imm_valid(imm_valid), .wb_en(wb_en), .wb_val(wb_val), .ind_req(ind_req)
);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  mod_sel = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [1:0]  index_size = '0;
  logic [31:0] field = '0;
  logic [2:0]  field_w = '0;
  logic [31:0] pc = '0;
  logic        out_valid, imm_valid, wb_en, ind_req;
  logic [31:0] ea, imm, wb_val;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R12";
  bit done = 0;

  always #5 clk = ~clk;

  ea_gen dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
    .mod_sel(mod_sel), .op_size(op_size), .base_val(base_val),
    .index_val(index_val), .index_size(index_size), .field(field),
    .field_w(field_w), .pc(pc), .out_valid(out_valid), .ea(ea), .imm(imm),
    .imm_valid(imm_valid), .wb_en(wb_en), .wb_val(wb_val), .ind_req(ind_req)
  );

  function automatic int fbits(logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      3'd5: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] zx(logic [31:0] v, int w);
    if (w >= 32) return v;
    return v & ((32'h1 << w) - 32'h1);
  endfunction

  function automatic logic [31:0] sx(logic [31:0] v, int w);
    logic signed [31:0] t;
    t = $signed(v << (32 - w));
    return t >>> (32 - w);
  endfunction

  function automatic int bytes_of(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] idx_val(logic [31:0] v, logic [1:0] s);
    return zx(v, 8 * bytes_of(s));
  endfunction

  // expected registered outputs
  logic        e_v = 0, e_immv = 0, e_wb = 0, e_ind = 0;
  logic [31:0] e_ea = 0, e_imm = 0, e_wbv = 0;
  string       e_tag = "R12";

  task automatic model();
    int w;
    int n;
    w = fbits(field_w);
    n = bytes_of(op_size);
    e_v = req_valid; e_immv = 0; e_wb = 0; e_ind = 0;
    e_ea = 0; e_imm = 0; e_wbv = 0;
    e_tag = cur_tag;
    if (!req_valid) return;
    case (mode)
      4'd1: e_ea = base_val;
      4'd2: e_ea = (field_w == 3'd0) ? base_val + zx(field, 2) * n
                                     : base_val + sx(field, w);
      4'd3: e_ea = base_val + sx(field, w) + idx_val(index_val, index_size) * n;
      4'd4: begin
        e_wb = 1;
        e_wbv = (mod_sel == 2'd0 || mod_sel == 2'd2) ? base_val + n : base_val - n;
        e_ea = (mod_sel == 2'd1 || mod_sel == 2'd2) ? e_wbv : base_val;
      end
      4'd5: begin
        if (w == 8) e_ea = 32'hFFFF_FF00 | zx(field, 8);
        else if (w == 16) e_ea = sx(field, 16);
        else e_ea = zx(field, w);
      end
      4'd6: begin e_imm = zx(field, w); e_immv = 1; end
      4'd7: e_ea = pc + sx(field, w);
      4'd8: e_ea = pc + idx_val(index_val, index_size) * n;
      4'd9: begin e_ea = zx(field, 8) * 4; e_ind = 1; end
      4'd10: begin e_ea = 32'h200 + zx(field, 7) * 4; e_ind = 1; end
      default: e_ea = 0;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model advanced on every edge, compared just after it
  always @(posedge clk) begin
    if (rst) begin
      e_v = 0; e_immv = 0; e_wb = 0; e_ind = 0;
      e_ea = 0; e_imm = 0; e_wbv = 0; e_tag = "R12";
    end else begin
      model();
    end
    #1;
    if (!done) begin
      chk(e_v ? e_tag : "R1", "out_valid", {31'b0, out_valid}, {31'b0, e_v});
      chk("R6", "wb_en", {31'b0, wb_en}, {31'b0, e_wb});
      chk("R11", "ind_req", {31'b0, ind_req}, {31'b0, e_ind});
      chk("R8", "imm_valid", {31'b0, imm_valid}, {31'b0, e_immv});
      if (e_v || rst) begin
        chk(e_tag, "ea", ea, e_ea);
        if (e_immv || rst) chk(e_tag, "imm", imm, e_imm);
        if (e_wb || rst) chk(e_tag, "wb_val", wb_val, e_wbv);
      end
    end
  end

  task automatic issue(string tag, logic [3:0] m, logic [1:0] ms, logic [1:0] os,
                       logic [31:0] b, logic [31:0] ix, logic [1:0] isz,
                       logic [31:0] f, logic [2:0] fw, logic [31:0] p);
    @(negedge clk);
    cur_tag = tag; req_valid = 1; mode = m; mod_sel = ms; op_size = os;
    base_val = b; index_val = ix; index_size = isz; field = f;
    field_w = fw; pc = p;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = "R1"; req_valid = 0;
      field = 32'hDEAD_BEEF; base_val = 32'h5555_AAAA;
    end
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    issue("R2", 4'd1, 0, 2, 32'h0000_4000, 0, 0, 0, 0, 0);
    issue("R2", 4'd0, 0, 2, 32'h1234_5678, 0, 0, 32'h77, 3'd3, 32'h100);
    issue("R2", 4'd13, 0, 1, 32'h1234_5678, 0, 0, 32'h77, 3'd3, 32'h100);
    issue("R3", 4'd2, 0, 2, 32'h0000_1000, 0, 0, 32'h3, 3'd0, 0);
    issue("R3", 4'd2, 0, 1, 32'h0000_1000, 0, 0, 32'hFFFF_FFFE, 3'd0, 0);
    issue("R3", 4'd2, 0, 0, 32'h0000_1000, 0, 0, 32'h0000_FFFE, 3'd4, 0);
    issue("R3", 4'd2, 0, 2, 32'h0000_1000, 0, 0, 32'h8000_0000, 3'd6, 0);
    issue("R4", 4'd3, 0, 1, 32'h0010_0000, 32'hABCD_12F0, 0, 32'h0000_0010, 3'd4, 0);
    issue("R4", 4'd3, 0, 2, 32'h0010_0000, 32'hABCD_8001, 1, 32'h0000_8000, 3'd4, 0);
    issue("R4", 4'd3, 0, 0, 32'h0010_0000, 32'h0000_0100, 2, 32'hFFFF_FF00, 3'd6, 0);
    idle(1);
    issue("R5", 4'd4, 0, 2, 32'h0000_2000, 0, 0, 0, 0, 0);
    issue("R5", 4'd4, 1, 1, 32'h0000_2000, 0, 0, 0, 0, 0);
    idle(2);
    issue("R5", 4'd4, 2, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    issue("R5", 4'd4, 3, 2, 32'h0000_0002, 0, 0, 0, 0, 0);
    idle(1);
    issue("R7", 4'd5, 0, 0, 0, 0, 0, 32'h0000_0034, 3'd3, 0);
    issue("R7", 4'd5, 0, 0, 0, 0, 0, 32'h0000_8000, 3'd4, 0);
    issue("R7", 4'd5, 0, 0, 0, 0, 0, 32'h0000_1234, 3'd4, 0);
    issue("R7", 4'd5, 0, 0, 0, 0, 0, 32'hFF80_3456, 3'd5, 0);
    issue("R7", 4'd5, 0, 0, 0, 0, 0, 32'h8765_4321, 3'd6, 0);
    issue("R8", 4'd6, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 3'd1, 0);
    issue("R8", 4'd6, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 3'd2, 0);
    issue("R8", 4'd6, 0, 0, 0, 0, 0, 32'h1234_ABCD, 3'd4, 0);
    issue("R8", 4'd6, 0, 0, 0, 0, 0, 32'hCAFE_F00D, 3'd6, 0);
    issue("R9", 4'd7, 0, 0, 0, 0, 0, 32'h0000_0080, 3'd3, 32'h0000_1000);
    issue("R9", 4'd7, 0, 0, 0, 0, 0, 32'h0000_7FFF, 3'd4, 32'h0000_1000);
    issue("R10", 4'd8, 0, 1, 0, 32'hFFFF_00F1, 0, 0, 0, 32'h0000_1000);
    issue("R10", 4'd8, 0, 2, 0, 32'hFFFF_00F1, 1, 0, 0, 32'h0000_1000);
    issue("R11", 4'd9, 0, 0, 0, 0, 0, 32'hFFFF_FF25, 3'd3, 0);
    issue("R11", 4'd10, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 3'd3, 0);
    idle(2);
    issue("R12", 4'd4, 0, 2, 32'h0000_3000, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1; req_valid = 0;
    @(negedge clk);
    rst = 0;
    idle(3);
    done = 1;
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule